// File: doc/BRIEF.md
# Peripheral Clock Gate with Debug Suspend

This block governs the clock of a single peripheral. A debugger asserts a suspend request, and the block then stops the peripheral's clock enable under one of two policies. In the secure policy it waits until both the bus-side logic and the kernel are idle. In the fast policy it waits only for the bus side, so the kernel freezes as close as possible to the moment of the request. A programmable rate divider also produces a slower enable pulse for the kernel while the block is running.

Software reaches the block through one control register on a simple write/read port. The policy bit and the suspend-enable bit sit behind a guard. A write changes them only if the same write also sets a guard bit. The guard bit is never stored. An ordinary application write therefore cannot turn on fast shut-off or suspend by accident. A build parameter can fix the policy at fast, for peripherals that cannot drain in the secure way.

Register layout (RW = DIV_W+4 bits): bit 0 suspend enable, bit 1 fast policy, bit 2 write guard (write-only, reads 0), bit 3 suspended status (read-only), bits [DIV_W+3:4] rate divider.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset, the suspend-enable bit is 0, the fast-policy bit is 0 and the divider is 1. Reads return 0x010, `clk_en` is 1 and `suspended` is 0.
- R2: Bits 1 and 0 of a write update the fast-policy and suspend-enable bits only when bit 2 of the same write is 1. Otherwise both keep their values. Bit 2 always reads 0.
- R3: Every write loads bits [DIV_W+3:4] into the divider field, whatever the state of the guard bit. The field reads back unchanged.
- R4: While the suspend-enable bit is 0, a suspend request never stops the clock.
- R5: With the secure policy, the clock stops at the first rising edge where the request is active and both `bus_busy` and `core_busy` are 0. `suspended` is 1 and `clk_en` is 0 in the cycle after that edge.
- R6: With the fast policy, the clock stops at the first rising edge where the request is active and `bus_busy` is 0, whatever the value of `core_busy`.
- R7: When the parameter FORCE_FAST is 1, the fast policy applies even if the fast-policy bit is 0.
- R8: Once the request (or the suspend-enable bit) drops, `suspended` returns to 0 and `clk_en` returns to 1 one cycle later.
- R9: Once the clock is stopped, new `bus_busy` or `core_busy` activity does not restart it while the request stays active.
- R10: For a divider value N > 0, `core_en` pulses once every N cycles, and the first pulse comes N cycles after the write that loaded N. For N = 0, `core_en` never pulses.
- R11: `core_en` is 0 whenever `suspended` is 1.
- R12: Bit 3 of a read equals the `suspended` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational from state) |
| susp_req | input | 1 | Debug suspend request |
| bus_busy | input | 1 | Bus-side transaction outstanding |
| core_busy | input | 1 | Kernel operation in progress |
| clk_en | output | 1 | Gated-clock enable for the peripheral |
| core_en | output | 1 | Divided kernel enable pulse |
| suspended | output | 1 | Clock currently stopped by suspend |

## Verification
A register write shows up on `reg_rdata` in the cycle after its rising edge. A stop decision made at an edge shows up on `suspended`, `clk_en` and `core_en` in the cycle after that edge, and a release shows up one cycle after the edge that samples the dropped request. After a write of divider N, the first `core_en` pulse comes on the N-th cycle following the write edge. The bench drives inputs at the falling edge and steps a cycle-accurate model on the next rising edge. It compares outputs at the following falling edge, so every result is checked in exactly the cycle it becomes due.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } susp_st_e;

  localparam int B_SEN   = 0;
  localparam int B_FAST  = 1;
  localparam int B_GUARD = 2;
  localparam int B_STAT  = 3;
  localparam int B_DIV   = 4;
endpackage

// File: rtl/pcg_ctrl_reg.sv
module pcg_ctrl_reg #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_guard,
  input  logic             wr_fast,
  input  logic             wr_sen,
  input  logic [DIV_W-1:0] wr_div,
  output logic             sen_q,
  output logic             fast_q,
  output logic [DIV_W-1:0] div_q
);
  logic             sen_d, fast_d;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    sen_d  = sen_q;
    fast_d = fast_q;
    div_d  = div_q;
    if (wr_en) begin
      div_d = wr_div;
      if (wr_guard) begin
        sen_d  = wr_sen;
        fast_d = wr_fast;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_q  <= 1'b0;
      fast_q <= 1'b0;
      div_q  <= DIV_W'(1);
    end else begin
      sen_q  <= sen_d;
      fast_q <= fast_d;
      div_q  <= div_d;
    end
  end
endmodule

// File: rtl/pcg_suspend_fsm.sv
module pcg_suspend_fsm
  import pcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sen,
  input  logic fast_eff,
  input  logic req,
  input  logic bus_busy,
  input  logic core_busy,
  output logic halted
);
  susp_st_e st_q, st_d;
  logic     active, idle_ok;

  assign active  = sen & req;
  assign idle_ok = ~bus_busy & (fast_eff | ~core_busy);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (active) st_d = idle_ok ? ST_HALT : ST_DRAIN;
      ST_DRAIN: if (!active) st_d = ST_RUN;
                else if (idle_ok) st_d = ST_HALT;
      ST_HALT:  if (!active) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign halted = (st_q == ST_HALT);
endmodule

// File: rtl/pcg_rate_div.sv
module pcg_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             zero_ratio;

  assign zero_ratio = (ratio == '0);
  assign tick       = ~zero_ratio & (cnt_q == ratio - DIV_W'(1));

  always_comb begin
    if (restart || zero_ratio || tick) cnt_d = '0;
    else                               cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter bit FORCE_FAST = 1'b0,
  localparam int RW        = DIV_W + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          susp_req,
  input  logic          bus_busy,
  input  logic          core_busy,
  output logic          clk_en,
  output logic          core_en,
  output logic          suspended
);
  logic             sen_q, fast_q, fast_eff, halted, tick;
  logic [DIV_W-1:0] div_q;
  logic             unused_wbit;

  assign unused_wbit = reg_wdata[B_STAT];

  pcg_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .wr_guard (reg_wdata[B_GUARD]),
    .wr_fast  (reg_wdata[B_FAST]),
    .wr_sen   (reg_wdata[B_SEN]),
    .wr_div   (reg_wdata[B_DIV +: DIV_W]),
    .sen_q    (sen_q),
    .fast_q   (fast_q),
    .div_q    (div_q)
  );

  generate
    if (FORCE_FAST) begin : g_fast_only
      logic unused_fast;
      assign unused_fast = fast_q;
      assign fast_eff    = 1'b1;
    end else begin : g_selectable
      assign fast_eff = fast_q;
    end
  endgenerate

  pcg_suspend_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen       (sen_q),
    .fast_eff  (fast_eff),
    .req       (susp_req),
    .bus_busy  (bus_busy),
    .core_busy (core_busy),
    .halted    (halted)
  );

  pcg_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (reg_we),
    .ratio   (div_q),
    .tick    (tick)
  );

  assign suspended = halted;
  assign clk_en    = ~halted;
  assign core_en   = tick & ~halted;

  always_comb begin
    reg_rdata                   = '0;
    reg_rdata[B_SEN]            = sen_q;
    reg_rdata[B_FAST]           = fast_q;
    reg_rdata[B_STAT]           = halted;
    reg_rdata[B_DIV +: DIV_W]   = div_q;
  end
endmodule

// File: rtl/periph_clk_gate_chk.sv
module periph_clk_gate_chk #(
  parameter int DIV_W      = 8,
  parameter bit FORCE_FAST = 1'b0,
  localparam int RW        = DIV_W + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [RW-1:0] reg_wdata,
  input logic [RW-1:0] reg_rdata,
  input logic          susp_req,
  input logic          bus_busy,
  input logic          core_busy,
  input logic          clk_en,
  input logic          core_en,
  input logic          suspended
);
  // R5 R6 R7
  halt_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(susp_req && reg_rdata[0] && !bus_busy &&
                               (FORCE_FAST || reg_rdata[1] || !core_busy)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !susp_req) |=> !suspended);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && susp_req && reg_rdata[0]) |=> suspended);

  // R11
  core_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!core_en && !clk_en));

  // R2
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_wdata[2]) |=> $stable(reg_rdata[1:0]));

  // R10
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[RW-1:4] == '0) |-> !core_en);

  // R4
  no_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && !suspended) |=> !suspended);

  // R12
  stat_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3] == suspended);
endmodule

bind periph_clk_gate periph_clk_gate_chk #(.DIV_W(DIV_W), .FORCE_FAST(FORCE_FAST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .susp_req  (susp_req),
  .bus_busy  (bus_busy),
  .core_busy (core_busy),
  .clk_en    (clk_en),
  .core_en   (core_en),
  .suspended (suspended)
);

// File: tb/periph_clk_gate_tb_top.sv
module periph_clk_gate_tb_top;
  localparam int CLK_P = 10;
  localparam int DIV_W = 8;
  localparam int RW    = DIV_W + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we, susp_req, bus_busy, core_busy;
  logic [RW-1:0] reg_wdata;
  logic [RW-1:0] rdata, rdata_ff;
  logic          clk_en, core_en, suspended;
  logic          clk_en_ff, core_en_ff, suspended_ff;

  always #(CLK_P/2) clk = ~clk;

  periph_clk_gate #(.DIV_W(DIV_W), .FORCE_FAST(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .susp_req(susp_req), .bus_busy(bus_busy),
    .core_busy(core_busy), .clk_en(clk_en), .core_en(core_en),
    .suspended(suspended));

  periph_clk_gate #(.DIV_W(DIV_W), .FORCE_FAST(1'b1)) dut_ff_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_ff), .susp_req(susp_req), .bus_busy(bus_busy),
    .core_busy(core_busy), .clk_en(clk_en_ff), .core_en(core_en_ff),
    .suspended(suspended_ff));

  int n_chk = 0;
  int n_bad = 0;

  // reference model state (FORCE_FAST = 0)
  logic             m_sen, m_fast;
  logic [DIV_W-1:0] m_div, m_cnt;
  int               m_st; // 0 run, 1 drain, 2 halt

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic m_tick();
    return (m_div != 0) && (m_cnt == m_div - DIV_W'(1));
  endfunction

  function automatic logic [RW-1:0] m_rdata();
    return {m_div, (m_st == 2), 1'b0, m_fast, m_sen};
  endfunction

  task automatic model_edge();
    logic act, idle, tk;
    act  = m_sen && susp_req;
    idle = !bus_busy && (m_fast || !core_busy);
    tk   = m_tick();
    case (m_st)
      0: m_st = act ? (idle ? 2 : 1) : 0;
      1: m_st = !act ? 0 : (idle ? 2 : 1);
      default: m_st = act ? 2 : 0;
    endcase
    if (reg_we || m_div == 0 || tk) m_cnt = '0;
    else                            m_cnt = m_cnt + DIV_W'(1);
    if (reg_we) begin
      m_div = reg_wdata[RW-1:4];
      if (reg_wdata[2]) begin
        m_fast = reg_wdata[1];
        m_sen  = reg_wdata[0];
      end
    end
  endtask

  task automatic compare_model();
    check("R12 rdata", 32'(rdata), 32'(m_rdata()));
    check("R5 suspended", 32'(suspended), 32'(m_st == 2));
    check("R8 clk_en", 32'(clk_en), 32'(m_st != 2));
    check("R10 core_en", 32'(core_en), 32'(m_tick() && m_st != 2));
  endtask

  // entered at a falling edge; one rising edge, then back at a falling edge
  task automatic step(logic we, logic [RW-1:0] wd, logic req, logic bb, logic cb);
    reg_we = we; reg_wdata = wd; susp_req = req; bus_busy = bb; core_busy = cb;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_we = 1'b0;
    compare_model();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int pulses;
    logic rq;
    rst_n = 1'b0; reg_we = 0; reg_wdata = '0; susp_req = 0; bus_busy = 0; core_busy = 0;
    m_sen = 0; m_fast = 0; m_div = DIV_W'(1); m_cnt = '0; m_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_edge();

    // R1 reset state
    check("R1 rdata", 32'(rdata), 32'h010);
    check("R1 clk_en", 32'(clk_en), 32'h1);
    check("R1 suspended", 32'(suspended), 32'h0);

    // R2 guard
    step(1, 12'h013, 0, 0, 0);
    check("R2 unguarded write", 32'(rdata), 32'h010);
    step(1, 12'h017, 0, 0, 0);
    check("R2 guarded write", 32'(rdata), 32'h013);
    check("R2 guard reads 0", 32'(rdata[2]), 32'h0);

    // R3 divider field written without guard
    step(1, 12'h050, 0, 0, 0);
    check("R3 divider", 32'(rdata), 32'h053);

    // R4 suspend disabled
    step(1, 12'h014, 0, 0, 0);
    repeat (3) step(0, '0, 1, 0, 0);
    check("R4 no suspend", 32'(suspended), 32'h0);

    // R5 secure policy waits for kernel
    step(1, 12'h015, 0, 0, 0);
    repeat (3) step(0, '0, 1, 0, 1);
    check("R5 waits kernel", 32'(suspended), 32'h0);
    step(0, '0, 1, 0, 0);
    check("R5 stopped", 32'(suspended), 32'h1);
    check("R5 clk_en low", 32'(clk_en), 32'h0);
    check("R12 status bit", 32'(rdata[3]), 32'h1);
    check("R11 core_en off", 32'(core_en), 32'h0);

    // R9 busy ignored once stopped
    repeat (3) step(0, '0, 1, 1, 1);
    check("R9 stays stopped", 32'(suspended), 32'h1);

    // R8 release
    step(0, '0, 0, 1, 1);
    check("R8 released", 32'(clk_en), 32'h1);

    // R6 fast policy
    step(1, 12'h017, 0, 0, 0);
    step(0, '0, 1, 1, 1);
    check("R6 waits bus", 32'(suspended), 32'h0);
    step(0, '0, 1, 0, 1);
    check("R6 stopped with kernel busy", 32'(suspended), 32'h1);
    step(0, '0, 0, 0, 0);

    // R7 forced fast build
    step(1, 12'h015, 0, 0, 0);
    step(0, '0, 1, 0, 1);
    check("R7 secure instance runs", 32'(suspended), 32'h0);
    check("R7 forced instance stopped", 32'(suspended_ff), 32'h1);
    step(0, '0, 0, 0, 0);

    // R10 divider
    step(1, 12'h034, 0, 0, 0);
    pulses = 0;
    for (int k = 1; k <= 30; k++) begin
      step(0, '0, 0, 0, 0);
      if (k == 2) check("R10 no early pulse", 32'(pulses), 32'h0);
      pulses += int'(core_en);
    end
    check("R10 div3 pulses", 32'(pulses), 32'd10);
    step(1, 12'h004, 0, 0, 0);
    pulses = int'(core_en);
    for (int k = 0; k < 20; k++) begin
      step(0, '0, 0, 0, 0);
      pulses += int'(core_en);
    end
    check("R10 div0 pulses", 32'(pulses), 32'd0);
    step(1, 12'h014, 0, 0, 0);

    // random traffic against the model
    void'($urandom(32'd4711));
    rq = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [RW-1:0] wd;
      we = ($urandom % 8) == 0;
      wd = {DIV_W'($urandom % 5), 4'($urandom)};
      if (($urandom % 6) == 0) rq = ~rq;
      step(we, wd, rq, 1'($urandom), 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule